// File: doc/BRIEF.md
# Serial Converter Power-Mode Controller

This block is the digital power-mode control of a serial-output sampling converter. It watches the active-low chip-select and the serial clock and counts serial-clock falling edges inside each chip-select frame. When chip-select rises, the count decides the power mode. A rise before the keep threshold (10 edges by default) sends the part to power-down. A rise at or after the threshold leaves it powered. A full frame is 16 edges. This rule stops a short glitch on chip-select, or a short burst of clocks, from waking the part by accident.

The block also drives the track/hold enable, the enable of the serial data output (a three-state pin), a one-cycle pulse when the output lets go of the bus, and a powered-up status flag. A reference-clock timer models the fixed settling time of the analog section. The time is counted in reference cycles and does not depend on how many serial clocks arrive. The data bit itself comes from a stub input. Both pins are resynchronised into the reference-clock domain, and all logic runs on that clock.

States:
- `PM_DOWN`: powered down.
- `PM_WAKE`: a frame that began in power-down.
- `PM_IDLE`: powered, with chip-select high.
- `PM_FRAME`: a frame that began while powered.

Transitions:
- `PM_DOWN` to `PM_WAKE` on a chip-select fall.
- `PM_IDLE` to `PM_FRAME` on a chip-select fall.
- `PM_WAKE` or `PM_FRAME` to `PM_DOWN` when chip-select rises below the threshold.
- `PM_WAKE` or `PM_FRAME` to `PM_IDLE` when chip-select rises at or above the threshold.

Top module: `adc_pwr_fsm`

## Requirements
- R1: With START_ACTIVE=0, reset leaves `pwr_down`=1, `powered_up`=0, `track_en`=0 and `sdo_oe`=0.
- R2: If chip-select rises after fewer than KEEP_EDGE serial-clock falling edges in the frame, the block enters power-down (`pwr_down`=1). This holds whether the frame began in power-down or while powered.
- R3: If chip-select rises after KEEP_EDGE or more falling edges, the block goes to the powered idle state (`pwr_down`=0, `track_en`=1).
- R4: `powered_up` rises PWRUP_CYCLES reference cycles (plus synchroniser latency) after a chip-select fall in power-down. This happens even if no serial-clock falling edge has arrived.
- R5: In a frame that began in power-down, `track_en` stays 0 until the first serial-clock edge of either polarity after the chip-select fall, then becomes 1. `track_en` is 0 whenever `pwr_down`=1.
- R6: `powered_up` is 0 in every cycle where `pwr_down` is 1. It drops in the same cycle that power-down is entered.
- R7: `sdo_oe` is 1 only while chip-select is low and fewer than FRAME_LEN falling edges have been seen. `bus_released` is a single-cycle pulse in the cycle after `sdo_oe` falls.
- R8: Falling edges are counted only while chip-select is low, and each chip-select fall clears the count. Edges seen while chip-select is high have no effect on the next decision.
- R9: With START_ACTIVE=1, reset leaves the block in the powered idle state (`pwr_down`=0, `track_en`=1). `powered_up` becomes 1 once the timer expires.
- R10: `sdo` equals `conv_bit` while `sdo_oe`=1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| conv_bit | input | 1 | Stub conversion result bit |
| sdo | output | 1 | Serial data value (0 when not enabled) |
| sdo_oe | output | 1 | Output enable of the three-state data pin |
| track_en | output | 1 | 1 = track, 0 = hold |
| pwr_down | output | 1 | 1 while in power-down |
| powered_up | output | 1 | Analog section settled and powered |
| bus_released | output | 1 | One-cycle pulse when the data pin goes to three-state |

## Verification
The bench builds two copies of the block. The main copy uses START_ACTIVE=0, the default FRAME_LEN=16 and KEEP_EDGE=10, and PWRUP_CYCLES shortened to 40. A 40-cycle timer expires well inside a ten-edge frame but well outside the short early window of a frame with no clock edges. This makes both the timer-driven rise of `powered_up` and its immediate drop at power-down observable. The second copy uses START_ACTIVE=1 and covers the other power-on case. In that copy no pins toggle, so its reset state and the free-running timer expiry can be seen on their own.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;
    typedef enum logic [1:0] {
        PM_DOWN,
        PM_WAKE,
        PM_IDLE,
        PM_FRAME
    } pm_state_e;
endpackage

// File: rtl/adc_pm_sync.sv
module adc_pm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] shreg;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            shreg <= {shreg[STAGES-2:0], din};
            prev  <= shreg[STAGES-1];
        end
    end

    assign dout = shreg[STAGES-1];
    assign rise = shreg[STAGES-1] & ~prev;
    assign fall = ~shreg[STAGES-1] & prev;
endmodule

// File: rtl/adc_pm_edge_cnt.sv
module adc_pm_edge_cnt #(
    parameter int FRAME_LEN = 16,
    parameter int KEEP_EDGE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic keep_reached,
    output logic frame_done
);
    localparam int CW = $clog2(FRAME_LEN + 1);
    localparam logic [CW-1:0] FULL_V = CW'(FRAME_LEN);
    localparam logic [CW-1:0] KEEP_V = CW'(KEEP_EDGE);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != FULL_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign keep_reached = (cnt >= KEEP_V);
    assign frame_done   = (cnt == FULL_V);
endmodule

// File: rtl/adc_pm_timer.sv
module adc_pm_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);
    localparam logic [TW-1:0] END_V = TW'(CYCLES);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != END_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == END_V);
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
    import adc_pm_pkg::*;
#(
    parameter int FRAME_LEN    = 16,
    parameter int KEEP_EDGE    = 10,
    parameter int PWRUP_CYCLES = 200,
    parameter int SYNC_STAGES  = 2,
    parameter bit START_ACTIVE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic conv_bit,
    output logic sdo,
    output logic sdo_oe,
    output logic track_en,
    output logic pwr_down,
    output logic powered_up,
    output logic bus_released
);
    localparam pm_state_e RESET_ST = START_ACTIVE ? PM_IDLE : PM_DOWN;

    pm_state_e state, state_nx;

    logic cs_s, cs_rise, cs_fall;
    logic sclk_s, sclk_rise, sclk_fall;
    logic keep_reached, frame_done, tmr_done;
    logic seen_sclk, oe_r, oe_nx;

    adc_pm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n),
        .dout(cs_s), .rise(cs_rise), .fall(cs_fall)
    );

    adc_pm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .dout(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
    );

    adc_pm_edge_cnt #(.FRAME_LEN(FRAME_LEN), .KEEP_EDGE(KEEP_EDGE)) u_edges (
        .clk(clk), .rst_n(rst_n),
        .clr(cs_fall),
        .inc(sclk_fall & ~cs_s),
        .keep_reached(keep_reached),
        .frame_done(frame_done)
    );

    adc_pm_timer #(.CYCLES(PWRUP_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clr(state == PM_DOWN),
        .done(tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RESET_ST;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            PM_DOWN:  if (cs_fall) state_nx = PM_WAKE;
            PM_IDLE:  if (cs_fall) state_nx = PM_FRAME;
            PM_WAKE,
            PM_FRAME: if (cs_rise) state_nx = keep_reached ? PM_IDLE : PM_DOWN;
        endcase
    end

    // registered flags
    assign oe_nx = ~cs_s & ~frame_done & ~cs_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_sclk    <= 1'b0;
            oe_r         <= 1'b0;
            bus_released <= 1'b0;
            powered_up   <= 1'b0;
        end else begin
            if (cs_fall)                           seen_sclk <= 1'b0;
            else if (~cs_s & (sclk_rise | sclk_fall)) seen_sclk <= 1'b1;
            oe_r         <= oe_nx;
            bus_released <= oe_r & ~oe_nx;
            if (state_nx == PM_DOWN)   powered_up <= 1'b0;
            else if (tmr_done)         powered_up <= 1'b1;
        end
    end

    // state-decoded outputs
    always_comb begin
        pwr_down = 1'b0;
        track_en = 1'b1;
        unique case (state)
            PM_DOWN:  begin pwr_down = 1'b1; track_en = 1'b0; end
            PM_WAKE:  track_en = seen_sclk;
            PM_IDLE,
            PM_FRAME: track_en = 1'b1;
        endcase
    end

    assign sdo_oe = oe_r;
    assign sdo    = oe_r & conv_bit;
endmodule

// File: rtl/adc_pwr_fsm_chk.sv
module adc_pwr_fsm_chk (
    input logic clk,
    input logic rst_n,
    input logic sdo,
    input logic sdo_oe,
    input logic track_en,
    input logic pwr_down,
    input logic powered_up,
    input logic bus_released
);
    a_r6_no_pu_in_down: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !powered_up);

    a_r5_hold_in_down: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !track_en);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_released |=> !bus_released);

    a_r7_pulse_after_oe_fall: assert property (@(posedge clk) disable iff (!rst_n)
        bus_released |-> (!sdo_oe && $past(sdo_oe)));

    a_r10_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    a_r4_pu_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_up) |-> !pwr_down);
endmodule

bind adc_pwr_fsm adc_pwr_fsm_chk i_chk (
    .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe),
    .track_en(track_en), .pwr_down(pwr_down),
    .powered_up(powered_up), .bus_released(bus_released)
);

// File: tb/test_adc_pwr_fsm.sv
module test_adc_pwr_fsm;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic conv_bit = 1'b0;
    logic sdo, sdo_oe, track_en, pwr_down, powered_up, bus_released;
    logic b_sdo, b_oe, b_track, b_pd, b_pu, b_rel;

    int checks = 0;
    int failures = 0;
    int rel_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_pwr_fsm #(.PWRUP_CYCLES(40), .START_ACTIVE(1'b0)) i_adc_pwr_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_bit(conv_bit),
        .sdo(sdo), .sdo_oe(sdo_oe), .track_en(track_en), .pwr_down(pwr_down),
        .powered_up(powered_up), .bus_released(bus_released)
    );

    adc_pwr_fsm #(.PWRUP_CYCLES(40), .START_ACTIVE(1'b1)) i_adc_pwr_fsm_act (
        .clk(clk), .rst_n(rst_n), .cs_n(1'b1), .sclk(1'b0), .conv_bit(1'b0),
        .sdo(b_sdo), .sdo_oe(b_oe), .track_en(b_track), .pwr_down(b_pd),
        .powered_up(b_pu), .bus_released(b_rel)
    );

    typedef struct {
        string      tag;
        logic [3:0] exp;   // {pwr_down, powered_up, track_en, sdo_oe}
    } item_t;

    item_t sb_q[$];
    event  sb_ev;

    task automatic check_val(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // driver side: queue an expectation and wake the monitor
    task automatic expect_st(input string tag, input logic [3:0] exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        sb_q.push_back(it);
        ->sb_ev;
        @(negedge clk);
    endtask

    // monitor: compare queued expectations against outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check_val(it.tag, int'({pwr_down, powered_up, track_en, sdo_oe}), int'(it.exp));
            end
        end
    end

    always @(negedge clk) if (bus_released) rel_cnt++;

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_n = v;
        wait_n(6);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            wait_n(4);
            sclk = 1'b0;
            wait_n(4);
        end
        wait_n(4);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int c0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);
        expect_st("R1 reset state", 4'b1000);
        check_val("R9 active reset pwr_down", int'(b_pd), 0);
        check_val("R9 active reset track", int'(b_track), 1);
        check_val("R9 active reset powered_up", int'(b_pu), 0);
        wait_n(60);
        check_val("R9 active timer expiry", int'(b_pu), 1);

        // R5/R4: wake frame, no clock edges yet
        set_cs(1'b0);
        expect_st("R5 hold before first sclk edge", 4'b0001);
        wait_n(18);
        expect_st("R4 powered_up not before timer", 4'b0001);
        sclk = 1'b1;
        wait_n(6);
        expect_st("R5 track after first sclk edge", 4'b0011);
        wait_n(40);
        expect_st("R4 powered_up with no falling edges", 4'b0111);
        sclk = 1'b0;
        wait_n(6);
        set_cs(1'b1);
        expect_st("R2 early rise powers down; R6 pu drops", 4'b1000);

        // R2: glitch on chip-select
        set_cs(1'b0);
        set_cs(1'b1);
        expect_st("R2 chip-select glitch", 4'b1000);

        // R8: edges while chip-select high are not counted
        pulses(12);
        expect_st("R8 edges with cs high ignored", 4'b1000);
        set_cs(1'b0);
        pulses(9);
        expect_st("R7 oe during frame", 4'b0111);
        set_cs(1'b1);
        expect_st("R8 nine edges after cleared count", 4'b1000);

        // R3: ten edges keep the part powered
        set_cs(1'b0);
        pulses(10);
        set_cs(1'b1);
        expect_st("R3 keep threshold reached", 4'b0110);

        // R7/R10: full frame from idle
        set_cs(1'b0);
        expect_st("R7 frame from idle oe on", 4'b0111);
        conv_bit = 1'b1;
        wait_n(1);
        check_val("R10 sdo follows conv_bit 1", int'(sdo), 1);
        conv_bit = 1'b0;
        wait_n(1);
        check_val("R10 sdo follows conv_bit 0", int'(sdo), 0);
        conv_bit = 1'b1;
        c0 = rel_cnt;
        pulses(16);
        expect_st("R7 oe off after full frame", 4'b0110);
        check_val("R7 one release pulse", rel_cnt, c0 + 1);
        check_val("R10 sdo quiet when released", int'(sdo), 0);
        set_cs(1'b1);
        expect_st("R3 full frame stays powered", 4'b0110);
        check_val("R7 no second release pulse", rel_cnt, c0 + 1);
        conv_bit = 1'b0;

        // R2: power-down entry from powered idle
        set_cs(1'b0);
        c0 = rel_cnt;
        pulses(9);
        set_cs(1'b1);
        expect_st("R2 power-down from idle; R6", 4'b1000);
        check_val("R7 release on cs rise", rel_cnt, c0 + 1);

        wait_n(4);
        summary();
    end
endmodule